// File: doc/BRIEF.md
# Duty-Corrected Programmable Clock Divider

This block divides one input clock by a programmable integer ratio and drives one output clock. A 30-bit setting selects the ratio, which is always the setting plus one, so ratios run from 1 to 2^30. An invert control selects the output polarity.

The output stays even for every ratio that allows it. Even ratios give a high phase of exactly half the output period. A setting of zero bypasses the divider, so the input clock is passed through unchanged and keeps its own duty cycle. Odd ratios above one hold the output high for (N-1)/2 input periods. The high phase then ends on the next falling edge of the input, not on a rising edge, which gives a duty of (N-1+2X)/(2N) for an input high fraction X.

New settings and a new polarity take effect only where one output cycle ends and the next begins, so no runt pulses appear. While reset is asserted, the output sits at the inactive level for the polarity presented on the invert input.

Top module: `clkdiv_duty`

## Requirements
- R1: The output period is (div_val_i + 1) input periods; a setting of 3 gives an 80 ns period from a 20 ns input.
- R2: For an even ratio, the output high and low times are each exactly half the output period, at any input duty.
- R3: A setting of 0 passes the input clock to the output, so the output high and low times equal those of the input (swapped when inverted).
- R4: For odd N > 1, the non-inverted high time is (N-1)/2 input periods plus the input high time; N=5 with a 4 ns high in a 20 ns input gives 44 ns high, 56 ns low (44 %).
- R5: For odd N > 1 and non-inverted output, the output rises on an input rising edge and falls on an input falling edge.
- R6: With invert_i = 1, the output is the complement of the non-inverted waveform, so for odd N the output rises on an input falling edge and falls on an input rising edge.
- R7: A setting change made during an output cycle leaves that cycle's high and low times intact; the new ratio starts at the next cycle boundary.
- R8: While rst_ni is low, clk_o equals invert_i (output inactive), and the divide counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_val_i | input | 30 | Divide setting; ratio is value plus one |
| invert_i | input | 1 | Output polarity select, 1 = inverted |
| clk_o | output | 1 | Divided clock output |

## Verification
Two things can fall on the same input edge. The first is the end of a divide cycle, where the held setting is reloaded. The second is a change of div_val_i. The bench changes the setting shortly after an output rising edge of a long ratio. It then times the edges that follow: the old high and low phases must keep their full length, and the first edge of the new ratio must appear only at the boundary. A second overlap comes from the odd-ratio stretch, where the falling-edge register and the mode decode meet at the output. For each polarity, the bench checks which input edge each output edge lines up with.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_EVEN = 2'd1,
    MODE_ODD  = 2'd2
  } div_mode_e;
endpackage

// File: rtl/clkdiv_cfg.sv
`timescale 1ns/1ps
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  input  logic         inv_i,
  input  logic         wrap_i,
  output logic [W-1:0] last_o,
  output logic [W:0]   half_nx_o,
  output div_mode_e    mode_o,
  output logic         inv_o,
  output logic         live_o
);
  localparam int HW = W + 1;

  logic [W-1:0] last_q;
  logic [HW-1:0] half_q;
  div_mode_e    mode_q;
  logic         inv_q;
  logic         live_q;

  function automatic logic [HW-1:0] half_of(input logic [W-1:0] v);
    logic [HW-1:0] ratio;
    ratio = {1'b0, v} + {{W{1'b0}}, 1'b1};
    return ratio >> 1;
  endfunction

  function automatic div_mode_e mode_of(input logic [W-1:0] v);
    if (v == '0)  return MODE_PASS;
    else if (v[0]) return MODE_EVEN;  // odd setting -> even ratio
    else           return MODE_ODD;
  endfunction

  // settings load only where a divide cycle restarts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      half_q <= '0;
      mode_q <= MODE_PASS;
      inv_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (wrap_i) begin
        last_q <= val_i;
        half_q <= half_of(val_i);
        mode_q <= mode_of(val_i);
        inv_q  <= inv_i;
      end
    end
  end

  assign half_nx_o = wrap_i ? half_of(val_i) : half_q;
  assign last_o    = last_q;
  assign mode_o    = mode_q;
  assign inv_o     = inv_q;
  assign live_o    = live_q;

  // R7: held settings never move inside a cycle
  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> ($stable(last_q) && $stable(inv_q) && $stable(mode_q)));
endmodule

// File: rtl/clkdiv_count.sv
`timescale 1ns/1ps
module clkdiv_count #(
  parameter int W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] last_i,
  input  logic [W:0]   half_nx_i,
  output logic         wrap_o,
  output logic         hi_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         hi_q, hi_d;

  assign wrap_o = (cnt_q == last_i);

  always_comb begin
    cnt_d = wrap_o ? '0 : cnt_q + {{(W-1){1'b0}}, 1'b1};
    hi_d  = ({1'b0, cnt_d} < half_nx_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

  assign hi_o = hi_q;

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i);
  p_wrap_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  p_rise_at_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_q) |-> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_fall.sv
`timescale 1ns/1ps
module clkdiv_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  output logic ext_o
);
  logic ext_q;

  // half-period delayed copy; OR-ed in for odd ratios
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 1'b0;
    else         ext_q <= hi_i;
  end

  assign ext_o = ext_q;

  // R4: stretch copy equals the rising-edge phase by the next rising edge
  p_ext_tracks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q == hi_i);
endmodule

// File: rtl/clkdiv_duty.sv
`timescale 1ns/1ps
module clkdiv_duty
  import clkdiv_pkg::*;
#(
  parameter int W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_val_i,
  input  logic         invert_i,
  output logic         clk_o
);
  logic [W-1:0] last;
  logic [W:0]   half_nx;
  div_mode_e    mode;
  logic         inv, live, wrap, hi, ext;
  logic         lvl;

  clkdiv_cfg #(.W(W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .val_i     (div_val_i),
    .inv_i     (invert_i),
    .wrap_i    (wrap),
    .last_o    (last),
    .half_nx_o (half_nx),
    .mode_o    (mode),
    .inv_o     (inv),
    .live_o    (live)
  );

  clkdiv_count #(.W(W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .last_i    (last),
    .half_nx_i (half_nx),
    .wrap_o    (wrap),
    .hi_o      (hi)
  );

  clkdiv_fall u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hi_i   (hi),
    .ext_o  (ext)
  );

  always_comb begin
    unique case (mode)
      MODE_PASS: lvl = clk_i;
      MODE_EVEN: lvl = hi;
      MODE_ODD:  lvl = hi | ext;
      default:   lvl = hi;
    endcase
  end

  // inactive level until the first cycle starts
  assign clk_o = (rst_ni && live) ? (lvl ^ inv) : invert_i;

  // R3: divider phase stays idle in bypass
  p_pass_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_PASS) |-> !hi);
endmodule

// File: tb/tb_clkdiv_duty.sv
`timescale 1ns/1ps
module tb_clkdiv_duty;
  localparam realtime TCK = 20.0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [29:0] div_val_i = 30'd3;
  logic        invert_i = 1'b0;
  logic        clk_o;

  realtime hi_ns = 10.0;
  int n_chk = 0;
  int n_fail = 0;

  clkdiv_duty dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_val_i (div_val_i),
    .invert_i  (invert_i),
    .clk_o     (clk_o)
  );

  initial begin
    forever begin
      #(TCK - hi_ns) clk_i = 1'b1;
      #(hi_ns)       clk_i = 1'b0;
    end
  end

  task automatic chk_t(input string req, input realtime act, input realtime exp);
    n_chk++;
    if ((act - exp > 0.01) || (exp - act > 0.01)) begin
      n_fail++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic chk_b(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle(input logic [29:0] v, input logic inv, input realtime h);
    div_val_i = v;
    invert_i  = inv;
    hi_ns     = h;
    repeat (3) @(posedge clk_o);
  endtask

  task automatic measure(output realtime th, output realtime tl);
    realtime t0, t1, t2;
    @(posedge clk_o); t0 = $realtime;
    @(negedge clk_o); t1 = $realtime;
    @(posedge clk_o); t2 = $realtime;
    th = t1 - t0;
    tl = t2 - t1;
  endtask

  task automatic t_reset;
    #30;
    chk_b("R8 reset level non-inverted", clk_o, 1'b0);
    invert_i = 1'b1;
    #1;
    chk_b("R8 reset level inverted", clk_o, 1'b1);
    invert_i = 1'b0;
    #5 rst_ni = 1'b1;
  endtask

  task automatic t_even;
    realtime th, tl;
    settle(30'd3, 1'b0, 10.0);
    measure(th, tl);
    chk_t("R1 period div4", th + tl, 80.0);
    chk_t("R2 high div4 X=0.5", th, 40.0);
    settle(30'd3, 1'b0, 4.0);
    measure(th, tl);
    chk_t("R2 high div4 X=0.2", th, 40.0);
    chk_t("R2 low div4 X=0.2", tl, 40.0);
    settle(30'd5, 1'b0, 14.0);
    measure(th, tl);
    chk_t("R2 high div6 X=0.7", th, 60.0);
    chk_t("R1 period div6", th + tl, 120.0);
  endtask

  task automatic t_odd;
    realtime th, tl;
    settle(30'd4, 1'b0, 4.0);
    measure(th, tl);
    chk_t("R4 high div5 X=0.2", th, 44.0);
    chk_t("R4 low div5 X=0.2", tl, 56.0);
    settle(30'd2, 1'b0, 14.0);
    measure(th, tl);
    chk_t("R4 high div3 X=0.7", th, 34.0);
    chk_t("R4 low div3 X=0.7", tl, 26.0);
    @(posedge clk_o); #0.1;
    chk_b("R5 rise on input rise", clk_i, 1'b1);
    @(negedge clk_o); #0.1;
    chk_b("R5 fall on input fall", clk_i, 1'b0);
  endtask

  task automatic t_bypass;
    realtime th, tl;
    settle(30'd0, 1'b0, 4.0);
    measure(th, tl);
    chk_t("R3 bypass high", th, 4.0);
    chk_t("R3 bypass low", tl, 16.0);
    settle(30'd0, 1'b1, 4.0);
    measure(th, tl);
    chk_t("R3 bypass inverted high", th, 16.0);
    chk_t("R3 bypass inverted low", tl, 4.0);
  endtask

  task automatic t_invert;
    realtime th, tl;
    settle(30'd4, 1'b1, 4.0);
    measure(th, tl);
    chk_t("R6 inverted high div5", th, 56.0);
    chk_t("R6 inverted low div5", tl, 44.0);
    @(posedge clk_o); #0.1;
    chk_b("R6 inverted rise on input fall", clk_i, 1'b0);
    @(negedge clk_o); #0.1;
    chk_b("R6 inverted fall on input rise", clk_i, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk_b("R8 async reset inverted level", clk_o, 1'b1);
    #30 rst_ni = 1'b1;
  endtask

  task automatic t_boundary;
    realtime t0, t1, t2, t3;
    settle(30'd7, 1'b0, 10.0);
    @(posedge clk_o); t0 = $realtime;
    #25 div_val_i = 30'd1;
    @(negedge clk_o); t1 = $realtime;
    @(posedge clk_o); t2 = $realtime;
    @(negedge clk_o); t3 = $realtime;
    chk_t("R7 old high kept", t1 - t0, 80.0);
    chk_t("R7 old low kept", t2 - t1, 80.0);
    chk_t("R7 new ratio after boundary", t3 - t2, 20.0);
  endtask

  initial begin
    #(4_000_000.0);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_even();
    t_odd();
    t_bypass();
    t_invert();
    t_boundary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule